// File: doc/BRIEF.md
# Stereo Sample Concealment and Soft Mute

This block takes a two-channel serial PCM stream (bit clock, data, word select and a per-word error flag) and turns it into a stream of corrected parallel samples, one channel at a time, each marked by a single-cycle valid strobe. Every incoming word is held for one word period per channel. This lets the block see the next sample before it decides what to emit for a flagged one. A flagged sample is replaced by the rounded midpoint of the last trusted sample and its successor. During a burst of flagged samples the last trusted value is held.

After concealment the sample passes through a level stage. An active-low attenuation control cuts the level by 12 dB with a two-place arithmetic shift. An active-low mute control drives a gain register that walks between full scale and silence in sixteenth steps, one step per stereo frame. The block sits behind a disc or link decoder and in front of an oversampling filter. All logic runs on one system clock. The serial bit clock is treated as a data input, and its rising edges are detected in that domain.

Top module: `pcm_repair`

## Requirements
- R1: Words are shifted in MSB first on bit-clock rising edges. A word starts when the sampled word select differs from its value at the previous edge, and it completes on its 16th bit. Word select 0 marks the left channel and 1 the right. Bits after the 16th are ignored. The error flag is taken only on the 16th bit's edge.
- R2: The stream decodes identically with a bit-clock period of 4 and of 8 system clocks.
- R3: An unflagged sample is emitted unchanged, apart from the level stage, when the next word of its channel completes. The first word of each channel after reset produces no output.
- R4: A flagged sample followed by an unflagged one is emitted as floor((L + N + 1) / 2), where L is the last unflagged sample of that channel (0 after reset) and N is the next sample.
- R5: A flagged sample whose successor is also flagged is emitted as L, the last unflagged sample.
- R6: While the attenuation input is low, the concealed sample is arithmetically shifted right by two places before gain is applied.
- R7: The output is floor(x * g / 16) with gain g in 0..16. After each right-channel output, g drops by one while mute is low and rises by one while mute is high, stopping at 0 and at 16. A change of the mute input reverses the walk from the current g.
- R8: A synchronous reset clears the valid strobe and all sample history, and sets g to 16.
- R9: Results are clamped to the signed 16-bit range. Full-scale inputs of either sign pass through at unity gain without wrapping.
- R10: The valid strobe lasts one cycle, and the channel output gives the channel of the sample presented with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_clk | input | 1 | Serial bit clock, 1/4 or 1/8 of clk |
| ser_data | input | 1 | Serial sample data, MSB first |
| word_sel | input | 1 | Channel select, 0 left, 1 right |
| err_flag | input | 1 | Sample error flag, taken with the 16th bit |
| atten_n | input | 1 | Active-low 12 dB attenuation |
| mute_n | input | 1 | Active-low soft mute, idles high |
| sample_o | output | 16 | Corrected signed sample |
| chan_o | output | 1 | Channel of sample_o |
| valid_o | output | 1 | One-cycle strobe for sample_o |

## Verification
The checks assume that the bit clock has a period of at least four system clocks, so that rising edges and completed words are far apart and an output strobe never follows another in the next cycle. They also assume that data, word select and the flag are steady on the system edge where a bit-clock rise is seen, and that the control inputs do not move in the cycle the level stage consumes a sample. The stimulus changes all serial inputs on falling system-clock edges, while the bit clock is low. It moves the attenuation and mute controls only in the middle of left-channel words, well away from the cycles in which outputs are produced.

// File: rtl/pcm_repair_pkg.sv
package pcm_repair_pkg;
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    localparam int N_CHAN = 2;
endpackage

// File: rtl/serial_word_rx.sv
module serial_word_rx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_clk,
    input  logic         ser_data,
    input  logic         word_sel,
    input  logic         err_flag,
    output logic         word_vld,
    output logic [W-1:0] word,
    output logic         word_ch,
    output logic         word_err
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          clk_prev;
        logic          ws;
        logic [CW-1:0] cnt;
        logic [W-1:0]  sh;
        logic          vld;
        logic [W-1:0]  word;
        logic          ch;
        logic          err;
    } rx_t;

    rx_t st_d, st_q;
    logic rise;

    always_comb begin
        st_d          = st_q;
        st_d.vld      = 1'b0;
        st_d.clk_prev = bit_clk;
        rise          = bit_clk & ~st_q.clk_prev;
        if (rise) begin
            st_d.ws = word_sel;
            if (word_sel != st_q.ws) begin
                st_d.cnt = CW'(1);
                st_d.sh  = {{(W-1){1'b0}}, ser_data};
            end else if (st_q.cnt < CW'(W)) begin
                st_d.cnt = st_q.cnt + CW'(1);
                st_d.sh  = {st_q.sh[W-2:0], ser_data};
                if (st_q.cnt == CW'(W - 1)) begin
                    st_d.vld  = 1'b1;
                    st_d.word = {st_q.sh[W-2:0], ser_data};
                    st_d.ch   = word_sel;
                    st_d.err  = err_flag;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_vld = st_q.vld;
    assign word     = st_q.word;
    assign word_ch  = st_q.ch;
    assign word_err = st_q.err;
endmodule

// File: rtl/conceal_lane.sv
module conceal_lane #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [W-1:0] in_word,
    input  logic         in_err,
    output logic         out_vld,
    output logic [W-1:0] out_smp
);
    typedef struct packed {
        logic         have_pend;
        logic [W-1:0] pend;
        logic         pend_err;
        logic [W-1:0] last_good;
        logic         vld;
        logic [W-1:0] smp;
    } lane_t;

    lane_t st_d, st_q;
    logic signed [W:0] mid_sum;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        mid_sum  = $signed({st_q.last_good[W-1], st_q.last_good})
                 + $signed({in_word[W-1], in_word})
                 + $signed((W+1)'(1));
        if (in_vld) begin
            if (st_q.have_pend) begin
                st_d.vld = 1'b1;
                if (!st_q.pend_err) begin
                    st_d.smp       = st_q.pend;
                    st_d.last_good = st_q.pend;
                end else if (!in_err) begin
                    st_d.smp = mid_sum[W:1];
                end else begin
                    st_d.smp = st_q.last_good;
                end
            end
            st_d.pend      = in_word;
            st_d.pend_err  = in_err;
            st_d.have_pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_smp = st_q.smp;
endmodule

// File: rtl/level_ramp.sv
module level_ramp #(
    parameter int W         = 16,
    parameter int GAIN_BITS = 4,
    parameter int ATT_SHIFT = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic                 in_ch,
    input  logic [W-1:0]         in_smp,
    input  logic                 atten_n,
    input  logic                 mute_n,
    output logic                 out_vld,
    output logic                 out_ch,
    output logic [W-1:0]         out_smp,
    output logic [GAIN_BITS:0]   gain
);
    import pcm_repair_pkg::*;

    localparam int GW = GAIN_BITS + 1;
    localparam int PW = W + GW + 1;
    localparam logic [GW-1:0] FULL = GW'(1 << GAIN_BITS);
    localparam logic signed [PW-1:0] SMAX = PW'((1 << (W - 1)) - 1);
    localparam logic signed [PW-1:0] SMIN = ~SMAX;

    typedef struct packed {
        logic          vld;
        logic          ch;
        logic [W-1:0]  smp;
        logic [GW-1:0] gain;
    } lvl_t;

    lvl_t st_d, st_q;
    logic signed [W-1:0]  x_in;
    logic signed [W-1:0]  x_att;
    logic signed [PW-1:0] x_ext;
    logic signed [PW-1:0] g_ext;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;

    function automatic logic [W-1:0] clamp(input logic signed [PW-1:0] v);
        if (v > SMAX) begin
            return SMAX[W-1:0];
        end else if (v < SMIN) begin
            return SMIN[W-1:0];
        end
        return v[W-1:0];
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        x_in     = $signed(in_smp);
        x_att    = atten_n ? x_in : (x_in >>> ATT_SHIFT);
        x_ext    = PW'(x_att);
        g_ext    = $signed(PW'(st_q.gain));
        prod     = x_ext * g_ext;
        scaled   = prod >>> GAIN_BITS;
        if (in_vld) begin
            st_d.vld = 1'b1;
            st_d.ch  = in_ch;
            st_d.smp = clamp(scaled);
            if (in_ch == CH_RIGHT) begin
                if (!mute_n) begin
                    if (st_q.gain != '0) st_d.gain = st_q.gain - GW'(1);
                end else begin
                    if (st_q.gain != FULL) st_d.gain = st_q.gain + GW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.gain <= FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_ch  = st_q.ch;
    assign out_smp = st_q.smp;
    assign gain    = st_q.gain;
endmodule

// File: rtl/pcm_repair.sv
module pcm_repair #(
    parameter int W         = 16,
    parameter int GAIN_BITS = 4,
    parameter int ATT_SHIFT = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_clk,
    input  logic         ser_data,
    input  logic         word_sel,
    input  logic         err_flag,
    input  logic         atten_n,
    input  logic         mute_n,
    output logic [W-1:0] sample_o,
    output logic         chan_o,
    output logic         valid_o
);
    import pcm_repair_pkg::*;

    logic         rx_vld;
    logic [W-1:0] rx_word;
    logic         rx_ch;
    logic         rx_err;

    logic [N_CHAN-1:0] lane_vld;
    logic [W-1:0]      lane_smp [N_CHAN];

    logic         mix_vld;
    logic         mix_ch;
    logic [W-1:0] mix_smp;
    logic [GAIN_BITS:0] gain_w;

    serial_word_rx #(.W(W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .bit_clk  (bit_clk),
        .ser_data (ser_data),
        .word_sel (word_sel),
        .err_flag (err_flag),
        .word_vld (rx_vld),
        .word     (rx_word),
        .word_ch  (rx_ch),
        .word_err (rx_err)
    );

    for (genvar c = 0; c < N_CHAN; c++) begin : g_lane
        conceal_lane #(.W(W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (rx_vld && (rx_ch == 1'(c))),
            .in_word (rx_word),
            .in_err  (rx_err),
            .out_vld (lane_vld[c]),
            .out_smp (lane_smp[c])
        );
    end

    assign mix_vld = |lane_vld;
    assign mix_ch  = lane_vld[CH_RIGHT];
    assign mix_smp = lane_vld[CH_RIGHT] ? lane_smp[CH_RIGHT] : lane_smp[CH_LEFT];

    level_ramp #(.W(W), .GAIN_BITS(GAIN_BITS), .ATT_SHIFT(ATT_SHIFT)) u_lvl (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (mix_vld),
        .in_ch   (mix_ch),
        .in_smp  (mix_smp),
        .atten_n (atten_n),
        .mute_n  (mute_n),
        .out_vld (valid_o),
        .out_ch  (chan_o),
        .out_smp (sample_o),
        .gain    (gain_w)
    );
endmodule

// File: rtl/pcm_repair_chk.sv
module pcm_repair_chk #(
    parameter int W         = 16,
    parameter int GAIN_BITS = 4,
    parameter int ATT_SHIFT = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               atten_n,
    input logic               valid_o,
    input logic [W-1:0]       sample_o,
    input logic [GAIN_BITS:0] gain
);
    localparam logic [GAIN_BITS:0] FULL = (GAIN_BITS+1)'(1 << GAIN_BITS);
    localparam int AMAX = (1 << (W - 1 - ATT_SHIFT)) - 1;
    localparam int AMIN = -(1 << (W - 1 - ATT_SHIFT));

    // R8: first cycle out of reset shows no strobe and full gain
    a_r8_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!valid_o && gain == FULL));

    // R10: strobe is a single-cycle pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R7: gain moves at most one step per cycle and stays in range
    a_r7_gain_step: assert property (@(posedge clk) disable iff (rst)
        ($past(gain) == gain) || ($past(gain) + 1'b1 == gain) || (gain + 1'b1 == $past(gain)));

    a_r7_gain_range: assert property (@(posedge clk) disable iff (rst)
        gain <= FULL);

    // R7: zero gain yields silence
    a_r7_silent_at_zero: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(gain) == '0) |-> (sample_o == '0));

    // R6: attenuated output stays within the reduced range
    a_r6_atten_range: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !$past(atten_n)) |->
        (($signed(sample_o) <= AMAX) && ($signed(sample_o) >= AMIN)));
endmodule

bind pcm_repair pcm_repair_chk #(.W(W), .GAIN_BITS(GAIN_BITS), .ATT_SHIFT(ATT_SHIFT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .atten_n  (atten_n),
    .valid_o  (valid_o),
    .sample_o (sample_o),
    .gain     (gain_w)
);

// File: tb/tb_pcm_repair.sv
`timescale 1ns/1ps
module tb_pcm_repair;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1;
    logic bit_clk = 1'b0, ser_data = 1'b0, word_sel = 1'b0, err_flag = 1'b0;
    logic atten_n = 1'b1, mute_n = 1'b1;
    logic [15:0] sample_o;
    logic chan_o, valid_o;

    pcm_repair dut (
        .clk(clk), .rst(rst), .bit_clk(bit_clk), .ser_data(ser_data),
        .word_sel(word_sel), .err_flag(err_flag), .atten_n(atten_n),
        .mute_n(mute_n), .sample_o(sample_o), .chan_o(chan_o), .valid_o(valid_o)
    );

    int n_run = 0, n_fail = 0;
    int half = 2;
    int m_have[2], m_pend[2], m_perr[2], m_last[2];
    int g = 16;
    int ev[0:1023];
    int ec[0:1023];
    string et[0:1023];
    int head = 0, tail = 0;
    bit done = 0;

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_have[c] = 0; m_pend[c] = 0; m_perr[c] = 0; m_last[c] = 0;
        end
        g = 16;
    endtask

    // Model of R3/R4/R5 concealment, R6 attenuation, R7 gain walk, R9 clamp
    task automatic model_push(input int val, input int ch, input int e);
        int x, v, p; string tag;
        if (m_have[ch] != 0) begin
            tag = "R3";
            if (m_perr[ch] == 0) begin
                x = m_pend[ch]; m_last[ch] = m_pend[ch];
            end else if (e == 0) begin
                x = (m_last[ch] + val + 1) >>> 1; tag = "R4";
            end else begin
                x = m_last[ch]; tag = "R5";
            end
            v = x;
            if (atten_n == 1'b0) begin v = v >>> 2; if (tag == "R3") tag = "R6"; end
            p = (v * g) >>> 4;
            if (p > 32767) p = 32767;
            if (p < -32768) p = -32768;
            if (g != 16 && tag == "R3") tag = "R7";
            if ((x == 32767 || x == -32768) && tag == "R3") tag = "R9";
            ev[tail[9:0]] = p; ec[tail[9:0]] = ch; et[tail[9:0]] = tag;
            tail++;
            if (ch == 1) begin
                if (mute_n == 1'b0) begin if (g > 0) g--; end
                else begin if (g < 16) g++; end
            end
        end
        m_pend[ch] = val; m_perr[ch] = e; m_have[ch] = 1;
    endtask

    // R1: MSB first, flag only on the 16th bit, extra bits ignored
    task automatic send_word(input int val, input int ch, input int e, input int nbits,
                             input bit chg, input bit new_att, input bit new_mute);
        logic [15:0] w;
        w = val[15:0];
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            bit_clk  = 1'b0;
            ser_data = (i < 16) ? w[15 - i] : 1'b1;
            word_sel = ch[0];
            err_flag = (i == 15) ? e[0] : 1'b0;
            if (chg && i == 8) begin atten_n = new_att; mute_n = new_mute; end
            if (i == 15) model_push($signed(w), ch, e);
            repeat (half - 1) @(negedge clk);
            @(negedge clk);
            bit_clk = 1'b1;
            repeat (half - 1) @(negedge clk);
        end
    endtask

    function automatic int val_of(input int ph, input int f, input int ch);
        if (f == 1) return ch == 0 ? 32767 : -32768;
        if (f == 2) return ch == 0 ? -32768 : 32767;
        if (f == 6) return 32767;
        if (f == 16) return -32768;
        return ((f * 7919 + ch * 12345 + ph * 999) % 65536) - 32768;
    endfunction

    function automatic int err_of(input int ph, input int f, input int ch);
        if (ph == 1) begin
            if (ch == 0) return (f == 0 || f == 3 || f == 7 || f == 8 || f == 12 ||
                                 f == 13 || f == 14 || f == 30 || f == 45) ? 1 : 0;
            return (f == 5 || f == 20 || f == 21 || f == 51) ? 1 : 0;
        end
        if (ch == 0) return (f == 2 || f == 9 || f == 10) ? 1 : 0;
        return (f == 4 || f == 11 || f == 12) ? 1 : 0;
    endfunction

    // mute schedule for phase 1: down to zero, up, reversal mid-walk, down again
    function automatic bit mute_of(input int f);
        if (f >= 20 && f <= 41) return 1'b0;
        if (f >= 50 && f <= 53) return 1'b0;
        if (f >= 62) return 1'b0;
        return 1'b1;
    endfunction

    // R10: every strobe matches the next expected sample and channel
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            n_run++;
            if (head == tail) begin
                n_fail++;
                $display("FAIL R10 unexpected strobe: got %0d expected none", $signed(sample_o));
            end else begin
                if ($signed(sample_o) != ev[head[9:0]] || chan_o != ec[head[9:0]][0]) begin
                    n_fail++;
                    $display("FAIL %s sample/chan: got %0d/%0d expected %0d/%0d",
                             et[head[9:0]], $signed(sample_o), chan_o, ev[head[9:0]], ec[head[9:0]]);
                end
                head++;
            end
        end
    end

    task automatic check_quiet(input string tag);
        @(negedge clk);
        n_run++;
        if (valid_o !== 1'b0) begin
            n_fail++;
            $display("FAIL %s strobe during/after reset: got %0b expected 0", tag, valid_o);
        end
    endtask

    task automatic drain_check();
        repeat (40) @(negedge clk);
        n_run++;
        if (head != tail) begin
            n_fail++;
            $display("FAIL R3 missing outputs: got %0d expected %0d", head, tail);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check_quiet("R8");
        rst = 1'b0;
        model_reset();

        // Phase 1, R2: bit clock at 1/4 of clk
        half = 2;
        for (int f = 0; f < 70; f++) begin
            send_word(val_of(1, f, 0), 0, err_of(1, f, 0), 16, 1'b1,
                      (f >= 56 && f <= 60) ? 1'b0 : 1'b1, mute_of(f));
            send_word(val_of(1, f, 1), 1, err_of(1, f, 1), 16, 1'b0, 1'b1, 1'b1);
        end
        @(negedge clk); bit_clk = 1'b0;
        drain_check();

        // R8: reset mid-run with low gain; history and gain restored
        @(negedge clk); rst = 1'b1;
        check_quiet("R8");
        @(negedge clk); rst = 1'b0; mute_n = 1'b1; atten_n = 1'b1; word_sel = 1'b0;
        model_reset();
        check_quiet("R8");

        // Phase 2, R2: bit clock at 1/8 of clk; R6 window; R1 overlong word
        half = 4;
        for (int f = 0; f < 30; f++) begin
            send_word(val_of(2, f, 0), 0, err_of(2, f, 0), (f == 20) ? 18 : 16, 1'b1,
                      (f >= 5 && f <= 15) ? 1'b0 : 1'b1, 1'b1);
            send_word(val_of(2, f, 1), 1, err_of(2, f, 1), 16, 1'b0, 1'b1, 1'b1);
        end
        @(negedge clk); bit_clk = 1'b0;
        drain_check();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog expired: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule